// File: doc/BRIEF.md
# Doze Clock Divisor Controller

This block holds a 16-bit clock-divisor control word and turns it into clock enables for a design that runs from one fast system clock. The enables take the place of divided clocks. An oscillator postscaler stage produces a peripheral-rate enable. A doze stage then thins that enable into a processor-rate enable, so the processor runs a selectable power-of-two factor slower than the peripherals.

Software writes the control word, and the word always reads back. An interrupt-event input can drop doze mode automatically when the recover option is set. The two PLL divider fields have no effect on the enables. They are stored, and their decoded divide values are presented on status outputs.

Control word layout: bit 0 doze enable, bits 3:1 doze select, bit 4 recover-on-interrupt, bit 5 unimplemented, bits 8:6 postscaler select, bits 10:9 PLL output divider code, bits 15:11 PLL input divider code.

Top module: `dozeclk_ctl`

## Requirements
- R1: A synchronous reset loads the control word with 0x00C0. That is postscaler code 011 and every other field 0. Both divider stages restart so that the postscaler ratio is 8 and the doze ratio is 1.
- R2: A write stores wr_data in the control word, and rd_data shows it from the next cycle on. Bit 5 always reads 0 and ignores writes.
- R3: With postscaler code c in bits 8:6, per_ce and osc_ce pulse once every 2^c cycles for c from 0 to 6. For c = 7 they pulse once every 256 cycles.
- R4: With doze enable (bit 0) at 1 and doze code d in bits 3:1, cpu_ce pulses once every 2^d per_ce pulses. Each cpu_ce pulse falls in the same cycle as a per_ce pulse.
- R5: With doze enable at 0, cpu_ce equals per_ce in every cycle, whatever the doze code holds.
- R6: When irq_evt is high, bit 4 is 1 and no write occurs in that cycle, the doze enable bit reads 0 from the next cycle on. When bit 4 is 0, irq_evt leaves the doze enable unchanged. A write in the same cycle as irq_evt takes priority.
- R7: A new postscaler or doze ratio takes effect only after the current period of that stage completes at its terminal count.
- R8: pll_post_div shows 2 for code 00, 4 for code 01, 4 for the reserved code 10 and 8 for code 11.
- R9: pll_pre_div shows the PLL input divider code plus 2, which is 2 to 33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| irq_evt | input | 1 | Interrupt event, one cycle per event |
| rd_data | output | 16 | Current control word |
| osc_ce | output | 1 | Postscaled oscillator enable |
| per_ce | output | 1 | Peripheral clock enable |
| cpu_ce | output | 1 | Processor clock enable |
| pll_pre_div | output | 6 | Decoded PLL input divide value |
| pll_post_div | output | 4 | Decoded PLL output divide value |

## Verification
A wrong count or a wrong latched ratio in either divider stage moves the next enable pulse. The bench model then sees per_ce or cpu_ce differ within one period of the affected stage, at most 256 cycles for the postscaler and 128 peripheral pulses for doze. A control word corrupted by a write, by the reserved bit or by an interrupt shows on rd_data one cycle later. The decoded PLL outputs are compared every cycle, so a bad mapping shows in the cycle after the write.

// File: rtl/dzc_pkg.sv
package dzc_pkg;

    localparam int CTRL_W       = 16;
    localparam int SEL_W        = 3;
    localparam int PRE_W        = 5;
    localparam int POST_W       = 2;
    localparam int OSC_RATIO_W  = 9;   // holds 256
    localparam int DOZE_RATIO_W = 8;   // holds 128
    localparam int PRE_VAL_W    = PRE_W + 1;
    localparam int POST_VAL_W   = 4;

    typedef struct packed {
        logic [PRE_W-1:0]  pll_pre;
        logic [POST_W-1:0] pll_post;
        logic [SEL_W-1:0]  osc_sel;
        logic              rsvd;
        logic              wake_on_irq;
        logic [SEL_W-1:0]  doze_sel;
        logic              doze_on;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        pll_pre: '0, pll_post: '0, osc_sel: 3'b011, rsvd: 1'b0,
        wake_on_irq: 1'b0, doze_sel: '0, doze_on: 1'b0
    };

    localparam logic [CTRL_W-1:0] WRITE_MASK = 16'hFFDF;

    localparam logic [OSC_RATIO_W-1:0]  OSC_RESET_RATIO  = 9'd8;
    localparam logic [DOZE_RATIO_W-1:0] DOZE_RESET_RATIO = 8'd1;

    function automatic logic [OSC_RATIO_W-1:0] osc_ratio(input logic [SEL_W-1:0] sel);
        if (sel == 3'b111) return 9'd256;
        return 9'd1 << sel;
    endfunction

    function automatic logic [DOZE_RATIO_W-1:0] doze_ratio(input logic [SEL_W-1:0] sel,
                                                           input logic on);
        if (!on) return 8'd1;
        return 8'd1 << sel;
    endfunction

    function automatic logic [POST_VAL_W-1:0] pll_post_val(input logic [POST_W-1:0] code);
        case (code)
            2'b00:   return 4'd2;
            2'b11:   return 4'd8;
            default: return 4'd4;   // 01 and reserved 10
        endcase
    endfunction

    function automatic logic [PRE_VAL_W-1:0] pll_pre_val(input logic [PRE_W-1:0] code);
        return {1'b0, code} + 6'd2;
    endfunction

endpackage

// File: rtl/dzc_ctrl_reg.sv
module dzc_ctrl_reg
    import dzc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              irq_evt,
    output ctrl_t             ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data & WRITE_MASK);
        end else if (irq_evt && ctrl_q.wake_on_irq) begin
            ctrl_q.doze_on <= 1'b0;
        end
    end

    // R6
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_evt && !wr_en && ctrl_q.wake_on_irq) |=> !ctrl_q.doze_on);

    // R6
    irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ctrl_q.wake_on_irq) |=> $stable(ctrl_q));

endmodule

// File: rtl/dzc_tc_div.sv
module dzc_tc_div #(
    parameter int              W           = 8,
    parameter logic [W-1:0]    RESET_RATIO = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] ratio_req,
    output logic         tc
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;
    logic [W-1:0] active;

    assign tc = tick && (cnt == active - ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= RESET_RATIO;
        end else if (tc) begin
            cnt    <= '0;
            active <= ratio_req;
        end else if (tick) begin
            cnt    <= cnt + ONE;
        end
    end

    // R7
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tc |=> $stable(active));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < active);

    // R4
    tc_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/dozeclk_ctl.sv
module dozeclk_ctl
    import dzc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [15:0]           wr_data,
    input  logic                  irq_evt,
    output logic [15:0]           rd_data,
    output logic                  osc_ce,
    output logic                  per_ce,
    output logic                  cpu_ce,
    output logic [5:0]            pll_pre_div,
    output logic [3:0]            pll_post_div
);

    ctrl_t ctrl;
    logic  osc_tc;
    logic  doze_tc;

    dzc_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .irq_evt (irq_evt),
        .ctrl_q  (ctrl)
    );

    dzc_tc_div #(.W(OSC_RATIO_W), .RESET_RATIO(OSC_RESET_RATIO)) u_osc_div (
        .clk       (clk),
        .rst       (rst),
        .tick      (1'b1),
        .ratio_req (osc_ratio(ctrl.osc_sel)),
        .tc        (osc_tc)
    );

    dzc_tc_div #(.W(DOZE_RATIO_W), .RESET_RATIO(DOZE_RESET_RATIO)) u_doze_div (
        .clk       (clk),
        .rst       (rst),
        .tick      (osc_tc),
        .ratio_req (doze_ratio(ctrl.doze_sel, ctrl.doze_on)),
        .tc        (doze_tc)
    );

    assign rd_data      = ctrl;
    assign osc_ce       = osc_tc;
    assign per_ce       = osc_tc;
    assign cpu_ce       = doze_tc;
    assign pll_pre_div  = pll_pre_val(ctrl.pll_pre);
    assign pll_post_div = pll_post_val(ctrl.pll_post);

    // R4
    cpu_in_per_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ce |-> per_ce);

    // R2
    write_back_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & 16'hFFDF)));

    // R8
    post_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(pll_post_div) == 1) && !pll_post_div[0]);

    // R9
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        (pll_pre_div >= 6'd2) && (pll_pre_div <= 6'd33));

endmodule

// File: tb/dozeclk_ctl_bench.sv
module dozeclk_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        irq_evt = 1'b0;
    logic [15:0] rd_data;
    logic        osc_ce, per_ce, cpu_ce;
    logic [5:0]  pll_pre_div;
    logic [3:0]  pll_post_div;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;

    // behavioural reference state
    logic [15:0] m_reg;
    int m_ocnt, m_oact, m_dcnt, m_dact;

    always #(CLK_PERIOD/2) clk = ~clk;

    dozeclk_ctl u_dozeclk_ctl (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .irq_evt (irq_evt), .rd_data (rd_data), .osc_ce (osc_ce),
        .per_ce (per_ce), .cpu_ce (cpu_ce), .pll_pre_div (pll_pre_div),
        .pll_post_div (pll_post_div)
    );

    function automatic int exp_osc(input int c);
        return (c == 7) ? 256 : (1 << c);
    endfunction

    function automatic int exp_post(input int c);
        if (c == 0) return 2;
        if (c == 3) return 8;
        return 4;
    endfunction

    function automatic logic [15:0] word(input int pre, input int post, input int osc,
                                         input int rec, input int dz, input int en);
        return {pre[4:0], post[1:0], osc[2:0], 1'b0, rec[0], dz[2:0], en[0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model update on the active edge
    always @(posedge clk) begin
        bit p_osc, p_cpu;
        if (rst) begin
            m_reg = 16'h00C0;
            m_ocnt = 0; m_oact = 8; m_dcnt = 0; m_dact = 1;
        end else begin
            p_osc = (m_ocnt == m_oact - 1);
            p_cpu = p_osc && (m_dcnt == m_dact - 1);
            if (p_osc) begin m_ocnt = 0; m_oact = exp_osc(int'(m_reg[8:6])); end
            else m_ocnt++;
            if (p_cpu) begin m_dcnt = 0; m_dact = m_reg[0] ? (1 << m_reg[3:1]) : 1; end
            else if (p_osc) m_dcnt++;
            if (wr_en) m_reg = wr_data & 16'hFFDF;
            else if (irq_evt && m_reg[4]) m_reg[0] = 1'b0;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit e_osc, e_cpu;
        if (chk_on && !done) begin
            e_osc = (m_ocnt == m_oact - 1);
            e_cpu = e_osc && (m_dcnt == m_dact - 1);
            check("R3 per_ce", per_ce, e_osc);
            check("R3 osc_ce", osc_ce, e_osc);
            check("R4 cpu_ce", cpu_ce, e_cpu);
            check("R2 rd_data", rd_data, m_reg);
            check("R9 pll_pre_div", pll_pre_div, int'(m_reg[15:11]) + 2);
            check("R8 pll_post_div", pll_post_div, exp_post(int'(m_reg[10:9])));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic write(input logic [15:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int gap, mism;
        idle(3);
        #1 rst = 1'b0;
        @(negedge clk);
        chk_on = 1'b1;
        // R1 reset state
        check("R1 rd_data", rd_data, 16'h00C0);
        check("R1 pll_pre_div", pll_pre_div, 2);
        check("R1 pll_post_div", pll_post_div, 2);
        idle(20);

        // R2 all ones, reserved bit reads 0
        write(16'hFFFF);
        check("R2 reserved bit", rd_data[5], 0);
        check("R2 rd_data", rd_data, 16'hFFDF);

        // R9 every input divider code, R8 every output divider code
        for (int p = 0; p < 32; p++) begin
            write(word(p, p % 4, 0, 0, 0, 0));
            check("R9 pre", pll_pre_div, p + 2);
            check("R8 post", pll_post_div, exp_post(p % 4));
        end
        write(word(0, 2, 0, 0, 0, 0));
        check("R8 reserved code", pll_post_div, 4);

        // R3 postscaler sweep
        for (int c = 0; c < 8; c++) begin
            write(word(1, 1, c, 0, 0, 0));
            idle(2 * exp_osc(c) + 300);
        end

        // R4 doze sweep with undivided postscaler
        write(word(0, 0, 0, 0, 0, 0));
        idle(300);
        for (int d = 0; d < 8; d++) begin
            write(word(0, 0, 0, 0, d, 1));
            idle(3 * (1 << d) + 10);
        end

        // R5 doze field ignored when disabled
        write(word(0, 0, 1, 0, 7, 0));
        idle(300);
        mism = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cpu_ce != per_ce) mism++;
        end
        check("R5 cpu_ce tracks per_ce", mism, 0);

        // R6 recover on interrupt
        write(word(0, 0, 0, 1, 3, 1));
        @(negedge clk); #1 irq_evt = 1'b1;
        @(negedge clk); #1 irq_evt = 1'b0;
        check("R6 doze cleared by irq", rd_data[0], 0);
        write(word(0, 0, 0, 0, 3, 1));
        @(negedge clk); #1 irq_evt = 1'b1;
        @(negedge clk); #1 irq_evt = 1'b0;
        check("R6 irq ignored when recover off", rd_data[0], 1);
        write(word(0, 0, 0, 1, 3, 0));
        @(negedge clk); #1 irq_evt = 1'b1; wr_en = 1'b1; wr_data = word(0, 0, 0, 1, 2, 1);
        @(negedge clk); #1 irq_evt = 1'b0; wr_en = 1'b0;
        check("R6 write wins over irq", rd_data[0], 1);
        idle(40);

        // R7 ratio change waits for terminal count
        write(word(0, 0, 3, 0, 0, 0));
        idle(300);
        @(negedge clk);
        while (!per_ce) @(negedge clk);
        #1 wr_en = 1'b1; wr_data = word(0, 0, 0, 0, 0, 0);
        @(negedge clk); #1 wr_en = 1'b0;
        gap = 1;
        while (!per_ce) begin @(negedge clk); gap++; end
        check("R7 old ratio finishes", gap, 8);
        @(negedge clk);
        gap = 1;
        while (!per_ce) begin @(negedge clk); gap++; end
        check("R7 new ratio applies", gap, 1);
        idle(10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule